// File: doc/BRIEF.md
# Single-Slope Conversion Sequencer

This block runs the digital side of a single-slope analog-to-digital converter. The ramp integrator, the input multiplexer, the threshold detector and the comparator are all outside the block. It drives a ramp-control line: high pulls the ramp down and holds it there, low lets it rise. It also drives a multiplexer select that picks the reference on one ramp and the signal on the next. Each conversion is a pair of ramps, reference first and signal second.

No start trigger exists for the ramp. A free-running counter timestamps the moment the ramp passes a small threshold above zero, and again the moment the comparator trips. The difference is the time spent above the threshold. The segment below the threshold is not measured. It is rebuilt from the reference time with a constant made of right shifts, and the same amount is added to both ramp times. A sequential restoring divider then forms the ratio of signal time to reference time. The result is a fraction of full scale, and it is presented with a one-cycle valid strobe.

Shift amounts, ramp-down length and trip timeout come from configuration registers. These registers load only while the sequencer is parked. Both sense inputs pass through a synchronizer chain before use.

Top module: `ssadc_ctrl`

## Requirements
- R1: Out of reset, and whenever the sequencer is parked, ramp_ctl_o is 1 and sel_ref_o is 1. While running, every ramp-down period between two ramps lasts exactly the configured fall length in clock cycles.
- R2: Ramps alternate between reference (sel_ref_o = 1) and signal (sel_ref_o = 0), with the reference first after starting. sel_ref_o changes only in cycles where ramp_ctl_o is 1.
- R3: The elapsed time of a ramp is the counter value when the comparator trips minus its value at the threshold crossing, modulo 2^CNT_W. The threshold and comparator inputs are treated alike, so their common delay cancels.
- R4: The below-threshold time equals the sum, over the enabled terms k, of the reference elapsed time shifted right by cfg_kt_shift_i[k*SH_W +: SH_W]. This amount is added to both the reference and the signal elapsed times.
- R5: The sample equals floor(signal_total * 2^OUT_W / reference_total). It saturates to 2^OUT_W - 1 whenever signal_total >= reference_total.
- R6: If the comparator is high in or before the cycle of the threshold crossing on either ramp of a pair, the ramp ends and the pair produces no sample.
- R7: If the comparator has not tripped once the ramp has been rising for cfg_timeout_i cycles, the ramp ends at once and the pair produces no sample.
- R8: A configuration write takes effect only while the sequencer is parked. A write at any other time leaves fall length, timeout and shift settings unchanged.
- R9: smp_valid_o is a single-cycle pulse, raised one cycle after the divider finishes. Each good pair yields exactly one pulse.
- R10: When en_i is low at the end of a signal ramp, the sequencer parks. The pair under way still completes and delivers its sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run request |
| cfg_we_i | input | 1 | Configuration write strobe, honoured only while parked |
| cfg_fall_len_i | input | CNT_W | Ramp-down length in cycles |
| cfg_timeout_i | input | CNT_W | Maximum rise time before a ramp is abandoned |
| cfg_kt_shift_i | input | KT_TERMS*SH_W | Right-shift amount of each correction term |
| cfg_kt_use_i | input | KT_TERMS | Enable of each correction term |
| thr_i | input | 1 | Threshold detector, high once the ramp is above the start threshold |
| cmp_i | input | 1 | Comparator, high once the ramp is above the held input |
| ramp_ctl_o | output | 1 | Ramp control: 1 discharges, 0 lets the ramp rise |
| sel_ref_o | output | 1 | Multiplexer select: 1 reference, 0 signal |
| smp_valid_o | output | 1 | Sample strobe |
| smp_o | output | OUT_W | Ratiometric sample, full scale equals the reference |

## Verification
The bench models the ramp as a level that climbs one unit per cycle while ramp control is low. Threshold and comparator levels come from chosen reference, threshold and signal voltages, so every expected sample follows from the voltage ratio alone. Signals at half scale, just above the threshold and near full scale check the time difference and the shift-add correction. Signals at or above the reference separate saturation from ordinary division. Signals at or below the threshold, and one beyond the timeout, must produce no sample. A second configuration with two correction terms and a shorter ramp-down shows that both terms are summed. A configuration write made while running must leave the measured ramp-down length and the samples unchanged.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FALL = 2'd1,
    ST_RISE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ssadc_sync.sv
module ssadc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else if (s == 0) stage_q[s] <= d_i;
          else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ssadc_ramp_seq.sv
module ssadc_ramp_seq
  import ssadc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] fall_len_i,
  input  logic [CNT_W-1:0] timeout_i,
  input  logic             thr_s_i,
  input  logic             cmp_s_i,
  output logic             ramp_ctl_o,
  output logic             sel_ref_o,
  output logic             idle_o,
  output logic             pair_done_o,
  output logic [CNT_W-1:0] ref_el_o,
  output logic [CNT_W-1:0] sig_el_o
);
  seq_state_e       state_q;
  logic             ramp_q, sel_q, thr_seen_q, ref_ok_q, pair_q;
  logic [CNT_W-1:0] tstamp_q, t_thr_q, fcnt_q, wcnt_q, ref_el_q, sig_el_q;
  logic [CNT_W-1:0] elapsed;
  logic             fall_last, trip_good, trip_early, timed_out, ramp_end;

  always_comb begin
    elapsed    = tstamp_q - t_thr_q;
    fall_last  = ({1'b0, fcnt_q} + 1'b1) >= {1'b0, fall_len_i};
    trip_good  = thr_seen_q && cmp_s_i;
    trip_early = !thr_seen_q && cmp_s_i;
    timed_out  = wcnt_q >= timeout_i;
    ramp_end   = trip_good || trip_early || timed_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ramp_q     <= 1'b1;
      sel_q      <= 1'b1;
      thr_seen_q <= 1'b0;
      ref_ok_q   <= 1'b0;
      pair_q     <= 1'b0;
      tstamp_q   <= '0;
      t_thr_q    <= '0;
      fcnt_q     <= '0;
      wcnt_q     <= '0;
      ref_el_q   <= '0;
      sig_el_q   <= '0;
    end else begin
      tstamp_q <= tstamp_q + 1'b1;
      pair_q   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (en_i) begin
            state_q <= ST_FALL;
            fcnt_q  <= '0;
          end
        end
        ST_FALL: begin
          if (fall_last) begin
            state_q    <= ST_RISE;
            ramp_q     <= 1'b0;
            wcnt_q     <= '0;
            thr_seen_q <= 1'b0;
          end else begin
            fcnt_q <= fcnt_q + 1'b1;
          end
        end
        ST_RISE: begin
          wcnt_q <= wcnt_q + 1'b1;
          if (!thr_seen_q && thr_s_i && !cmp_s_i) begin
            thr_seen_q <= 1'b1;
            t_thr_q    <= tstamp_q;
          end
          if (ramp_end) begin
            ramp_q <= 1'b1;
            fcnt_q <= '0;
            sel_q  <= !sel_q;
            if (sel_q) begin
              ref_el_q <= elapsed;
              ref_ok_q <= trip_good;
              state_q  <= ST_FALL;
            end else begin
              sig_el_q <= elapsed;
              pair_q   <= ref_ok_q && trip_good;
              state_q  <= en_i ? ST_FALL : ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ramp_ctl_o  = ramp_q;
  assign sel_ref_o   = sel_q;
  assign idle_o      = (state_q == ST_IDLE);
  assign pair_done_o = pair_q;
  assign ref_el_o    = ref_el_q;
  assign sig_el_o    = sig_el_q;

  // R1: parked state holds the ramp down on the reference input
  p_idle_parked_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (ramp_q && sel_q));
  // R2: select moves only while the ramp is held down
  p_sel_change_ramp_high_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> ramp_q);
  // R3: a good pair never reports a zero-length ramp
  p_elapsed_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    pair_q |-> (ref_el_q != '0 && sig_el_q != '0));
  // R7: the rise window never runs past the timeout
  p_rise_bounded_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RISE) |-> (wcnt_q <= timeout_i));
endmodule

// File: rtl/ssadc_kt_corr.sv
module ssadc_kt_corr #(
  parameter int CNT_W    = 16,
  parameter int SH_W     = 4,
  parameter int KT_TERMS = 2,
  parameter int TW       = CNT_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         ref_el_i,
  input  logic [CNT_W-1:0]         sig_el_i,
  input  logic [KT_TERMS*SH_W-1:0] shift_i,
  input  logic [KT_TERMS-1:0]      use_i,
  output logic                     done_o,
  output logic [TW-1:0]            ref_tot_o,
  output logic [TW-1:0]            sig_tot_o
);
  logic [TW-1:0] term [KT_TERMS];
  logic [TW-1:0] below;

  generate
    for (genvar k = 0; k < KT_TERMS; k++) begin : g_term
      assign term[k] = use_i[k] ? (TW'(ref_el_i) >> shift_i[k*SH_W +: SH_W]) : '0;
    end
  endgenerate

  always_comb begin
    below = '0;
    for (int k = 0; k < KT_TERMS; k++) below = below + term[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      ref_tot_o <= '0;
      sig_tot_o <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        ref_tot_o <= TW'(ref_el_i) + below;
        sig_tot_o <= TW'(sig_el_i) + below;
      end
    end
  end
endmodule

// File: rtl/ssadc_div.sv
module ssadc_div #(
  parameter int TW    = 18,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [TW-1:0]    num_i,
  input  logic [TW-1:0]    den_i,
  output logic             done_o,
  output logic [OUT_W-1:0] quo_o
);
  localparam int CW = $clog2(OUT_W + 1);

  logic             busy_q, done_q;
  logic [TW-1:0]    rem_q, den_q;
  logic [OUT_W-1:0] quo_q;
  logic [CW-1:0]    cnt_q;
  logic [TW:0]      rem_sh;
  logic             fits;

  always_comb begin
    rem_sh = {rem_q, 1'b0};
    fits   = rem_sh >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        den_q <= den_i;
        if (num_i >= den_i) begin
          quo_q  <= '1;
          done_q <= 1'b1;
        end else begin
          rem_q  <= num_i;
          quo_q  <= '0;
          cnt_q  <= CW'(OUT_W);
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        quo_q <= {quo_q[OUT_W-2:0], fits};
        rem_q <= fits ? TW'(rem_sh - {1'b0, den_q}) : rem_sh[TW-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R5: a new division never lands on one in progress
  p_start_idle_r5: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q);
  // R5: saturation when the numerator reaches the divisor
  p_saturate_r5: assert property (@(posedge clk) disable iff (rst)
    (start_i && (num_i >= den_i)) |=> (done_q && (quo_q == '1)));
endmodule

// File: rtl/ssadc_ctrl.sv
module ssadc_ctrl #(
  parameter int CNT_W       = 16,
  parameter int OUT_W       = 12,
  parameter int SH_W        = 4,
  parameter int KT_TERMS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_i,
  input  logic                     cfg_we_i,
  input  logic [CNT_W-1:0]         cfg_fall_len_i,
  input  logic [CNT_W-1:0]         cfg_timeout_i,
  input  logic [KT_TERMS*SH_W-1:0] cfg_kt_shift_i,
  input  logic [KT_TERMS-1:0]      cfg_kt_use_i,
  input  logic                     thr_i,
  input  logic                     cmp_i,
  output logic                     ramp_ctl_o,
  output logic                     sel_ref_o,
  output logic                     smp_valid_o,
  output logic [OUT_W-1:0]         smp_o
);
  localparam int TW = CNT_W + 2;
  localparam logic [CNT_W-1:0] FALL_RST = CNT_W'(16);

  logic [CNT_W-1:0]         fall_q, tmo_q;
  logic [KT_TERMS*SH_W-1:0] shift_q;
  logic [KT_TERMS-1:0]      use_q;
  logic [1:0]               sense_s;
  logic                     idle, pair_done, corr_done, div_done;
  logic [CNT_W-1:0]         ref_el, sig_el;
  logic [TW-1:0]            ref_tot, sig_tot;
  logic [OUT_W-1:0]         quo;
  logic                     valid_q;
  logic [OUT_W-1:0]         smp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_q  <= FALL_RST;
      tmo_q   <= '1;
      shift_q <= '0;
      use_q   <= '0;
    end else if (cfg_we_i && idle) begin
      fall_q  <= cfg_fall_len_i;
      tmo_q   <= cfg_timeout_i;
      shift_q <= cfg_kt_shift_i;
      use_q   <= cfg_kt_use_i;
    end
  end

  ssadc_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({thr_i, cmp_i}),
    .q_o (sense_s)
  );

  ssadc_ramp_seq #(.CNT_W(CNT_W)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .fall_len_i  (fall_q),
    .timeout_i   (tmo_q),
    .thr_s_i     (sense_s[1]),
    .cmp_s_i     (sense_s[0]),
    .ramp_ctl_o  (ramp_ctl_o),
    .sel_ref_o   (sel_ref_o),
    .idle_o      (idle),
    .pair_done_o (pair_done),
    .ref_el_o    (ref_el),
    .sig_el_o    (sig_el)
  );

  ssadc_kt_corr #(.CNT_W(CNT_W), .SH_W(SH_W), .KT_TERMS(KT_TERMS), .TW(TW)) corr_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (pair_done),
    .ref_el_i  (ref_el),
    .sig_el_i  (sig_el),
    .shift_i   (shift_q),
    .use_i     (use_q),
    .done_o    (corr_done),
    .ref_tot_o (ref_tot),
    .sig_tot_o (sig_tot)
  );

  ssadc_div #(.TW(TW), .OUT_W(OUT_W)) div_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (corr_done),
    .num_i   (sig_tot),
    .den_i   (ref_tot),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      smp_q   <= '0;
    end else begin
      valid_q <= div_done;
      if (div_done) smp_q <= quo;
    end
  end

  assign smp_valid_o = valid_q;
  assign smp_o       = smp_q;

  // R8: settings stay frozen while the sequencer runs
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    !idle |=> ($stable(fall_q) && $stable(tmo_q) && $stable(shift_q) && $stable(use_q)));
  // R9: the sample strobe is a single-cycle pulse
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    smp_valid_q_chk |=> !valid_q);
  logic smp_valid_q_chk;
  assign smp_valid_q_chk = valid_q;
endmodule

// File: tb/ssadc_ctrl_tb_top.sv
`timescale 1ns/1ps
module ssadc_ctrl_tb_top;
  localparam int CNT_W = 16, OUT_W = 12, SH_W = 4, KT_TERMS = 2, SYNC = 2;
  localparam int FULL = 1 << OUT_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, en = 1'b0, cfg_we = 1'b0;
  logic [CNT_W-1:0] cfg_fall = '0, cfg_tmo = '0;
  logic [KT_TERMS*SH_W-1:0] cfg_shift = '0;
  logic [KT_TERMS-1:0] cfg_use = '0;
  logic thr_b = 1'b0, cmp_b = 1'b0;
  logic ramp_ctl, sel_ref, smp_valid;
  logic [OUT_W-1:0] smp;

  ssadc_ctrl #(.CNT_W(CNT_W), .OUT_W(OUT_W), .SH_W(SH_W), .KT_TERMS(KT_TERMS),
               .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .en_i(en), .cfg_we_i(cfg_we),
    .cfg_fall_len_i(cfg_fall), .cfg_timeout_i(cfg_tmo),
    .cfg_kt_shift_i(cfg_shift), .cfg_kt_use_i(cfg_use),
    .thr_i(thr_b), .cmp_i(cmp_b),
    .ramp_ctl_o(ramp_ctl), .sel_ref_o(sel_ref),
    .smp_valid_o(smp_valid), .smp_o(smp));

  int checks = 0, fails = 0;
  int exp_q[$];
  int vq[$];
  int vref_b = 900, vt_b = 100, exp_fall = 20, exp_tmo = 2000;
  int level = 0, high_run = 0, low_run = 0, last_high = 0;
  int sig_starts = 0, samples = 0, cycles = 0;
  bit skip_fall = 1'b1, last_sel = 1'b0, prev_ramp = 1'b1, prev_sel = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural ramp, sensors and reference model, evaluated every clock
  always @(negedge clk) begin
    if (!rst) begin
      int vin;
      cycles++;
      if (cycles > 190000) begin
        chk(1'b0, "watchdog", cycles, 190000);
        finish_run();
      end
      level = ramp_ctl ? 0 : level + 1;
      vin   = sel_ref ? vref_b : ((vq.size() > 0) ? vq[0] : 0);
      thr_b = (level > vt_b);
      cmp_b = (level > vin);

      if (prev_ramp && !ramp_ctl) begin
        if (!skip_fall) chk(high_run == exp_fall, "R1 fall length", high_run, exp_fall);
        last_high = high_run;
        skip_fall = 1'b0;
        chk(sel_ref != last_sel, "R2 alternation", sel_ref, !last_sel);
        last_sel = sel_ref;
        low_run = 0;
        if (!sel_ref && vq.size() > 0) begin
          int v;
          v = vq[0];
          sig_starts++;
          if (v > vt_b && v < exp_tmo - 100)
            exp_q.push_back(((v * FULL) / vref_b > FULL - 1) ? FULL - 1 : (v * FULL) / vref_b);
        end
      end
      if (!prev_ramp && ramp_ctl) begin
        chk(low_run <= exp_tmo + SYNC + 3, "R7 rise bounded", low_run, exp_tmo + SYNC + 3);
        high_run = 0;
      end
      if (sel_ref != prev_sel)
        chk(ramp_ctl == 1'b1, "R2 select moves with ramp high", ramp_ctl, 1);
      if (!prev_sel && sel_ref && vq.size() > 0) void'(vq.pop_front());
      if (ramp_ctl) high_run++; else low_run++;

      if (smp_valid) begin
        samples++;
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected sample", smp, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(smp == OUT_W'(e), "R5 sample value", smp, e);
        end
      end
      prev_ramp = ramp_ctl;
      prev_sel  = sel_ref;
    end
  end

  task automatic cfg_write(input int fall, input int tmo, input int sh0, input int sh1,
                           input int use_mask);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_fall  = CNT_W'(fall);
    cfg_tmo   = CNT_W'(tmo);
    cfg_shift = {SH_W'(sh1), SH_W'(sh0)};
    cfg_use   = KT_TERMS'(use_mask);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    // stage A: Kt = 1/8 (R4 single term); stage B: Kt = 1/8 + 1/16 (R4 two terms)
    vq = '{450, 100, 899, 900, 1000, 50, 3000, 101, 675,
           760, 1000, 380, 1519, 241};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk(ramp_ctl == 1'b1, "R1 reset ramp high", ramp_ctl, 1);
    chk(sel_ref == 1'b1, "R1 reset select ref", sel_ref, 1);
    chk(smp_valid == 1'b0, "R9 reset no valid", smp_valid, 0);

    cfg_write(20, 2000, 3, 0, 1);
    en = 1'b1;
    wait (sig_starts == 2);
    cfg_write(3, 100, 0, 1, 3);   // R8: must be ignored while running
    wait (sig_starts == 4);
    chk(last_high == 20, "R8 write ignored while running", last_high, 20);
    wait (sig_starts == 9);
    @(negedge clk);
    en = 1'b0;
    repeat (3000) @(negedge clk);
    chk(ramp_ctl == 1'b1 && sel_ref == 1'b1, "R10 parked after stop", ramp_ctl, 1);
    chk(sig_starts == 9, "R10 no ramps after stop", sig_starts, 9);
    chk(exp_q.size() == 0, "R10 last pair delivered", exp_q.size(), 0);
    chk(samples == 6, "R6 R7 discarded pairs", samples, 6);

    vref_b = 1520; vt_b = 240; exp_fall = 5;
    cfg_write(5, 2000, 3, 4, 3);
    skip_fall = 1'b1;
    en = 1'b1;
    wait (sig_starts == 14);
    @(negedge clk);
    en = 1'b0;
    repeat (4000) @(negedge clk);
    chk(samples == 11, "R9 one pulse per pair", samples, 11);
    chk(exp_q.size() == 0, "R4 all corrected samples seen", exp_q.size(), 0);
    finish_run();
  end
endmodule